// File: doc/BRIEF.md
# Serial Flash Command Sequencer

The sequencer takes a single serial-flash operation descriptor and breaks it into an ordered chain of bursts for a downstream SPI master that owns the serial clock and the shift register. One descriptor holds an opcode, an address of zero to four bytes, a number of dummy bytes, a data length with a direction, and lane counts for the command, the address and the data. From it the block builds up to three kinds of burst. The first is a one-byte opcode burst. The second carries the address bytes and the dummy bytes together. The last is a data burst, which is cut into buffer-sized pieces when it is long. The master is told which burst should leave chip select asserted afterwards, so the whole operation goes out as one frame.

A user drives the descriptor fields and pulses `start`. The sequencer then supplies the opcode and address bytes itself. It passes write data from a byte stream to the master and forwards received bytes to a read stream. It pulses `done` when the last burst has finished. A descriptor whose lane layout it does not support is rejected without any burst, and `err` pulses together with `done`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `brq_start` are all low.
- R2: The first burst of every accepted operation is the opcode: one byte on one lane (`brq_len`=1, `brq_lanes`=1, `brq_rx`=0), carrying `d_opcode`. A descriptor with `d_cmd_lanes` other than 1 is rejected. Rejection means `done` and `err` pulse on the cycle after `start`, no burst is issued and `busy` stays low.
- R3: Lane counts are encoded as the values 1, 2 or 4. Only the command-address-data layouts 1-1-1, 1-1-2, 1-2-2, 1-1-4 and 1-4-4 are accepted, together with `d_addr_bytes` of 4 or less. Anything else is rejected in the way R2 describes.
- R4: When address bytes, dummy bytes and data length are all zero, the opcode burst has `brq_hold_cs`=0 and ends the operation.
- R5: When `d_addr_bytes`+`d_dummy_bytes` is non-zero, a second burst of that length uses `d_addr_lanes`. It carries the address most-significant byte first (byte `d_addr_bytes`-1 of `d_addr` first), followed by the dummy bytes as 0xFF.
- R6: The opcode burst holds chip select when any later phase exists. The address/dummy burst holds chip select only when the data length is non-zero.
- R7: A non-zero data length produces data bursts on `d_data_lanes` with `brq_rx`=`d_data_rx` (1 = receive). A transmit burst takes its bytes from `wr_data` (with `wr_ready`=`m_tx_ready`). A receive burst forwards `m_rx_data` to `rd_data` with `rd_valid`. Write and read streams are idle in all other phases.
- R8: Data longer than `BUF_BYTES` is split into bursts of `BUF_BYTES` bytes with chip select held. The final burst carries the remainder (1 to `BUF_BYTES`) and releases chip select.
- R9: A burst request is issued only after `brq_done` has closed the previous burst. The next request follows on the cycle after `brq_done`.
- R10: `done` is a single-cycle pulse on the cycle after `brq_done` of the final burst, and `busy` is low in that same cycle.
- R11: `start` is ignored while `busy` is high. Descriptor changes then do not alter the bursts or bytes of the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the descriptor when idle |
| d_opcode | input | 8 | Command byte |
| d_cmd_lanes | input | 3 | Lane count requested for the opcode |
| d_addr | input | 32 | Address, low bytes used |
| d_addr_bytes | input | 3 | Number of address bytes (0 to 4) |
| d_dummy_bytes | input | DUMMY_W | Number of dummy bytes |
| d_data_len | input | DLEN_W | Number of data bytes |
| d_data_rx | input | 1 | 1 = read data, 0 = write data |
| d_addr_lanes | input | 3 | Lane count of the address/dummy phase |
| d_data_lanes | input | 3 | Lane count of the data phase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Pulses with `done` on a rejected descriptor |
| brq_start | output | 1 | One-cycle burst request |
| brq_lanes | output | 3 | Lane count of the current burst |
| brq_len | output | LEN_W | Byte count of the current burst |
| brq_hold_cs | output | 1 | Keep chip select asserted after the burst |
| brq_rx | output | 1 | Current burst receives |
| brq_done | input | 1 | Master reports burst completion |
| m_tx_valid | output | 1 | Transmit byte available to the master |
| m_tx_data | output | 8 | Transmit byte |
| m_tx_ready | input | 1 | Master takes the transmit byte |
| m_rx_valid | input | 1 | Master presents a received byte |
| m_rx_data | input | 8 | Received byte |
| wr_valid | input | 1 | Write-data byte available |
| wr_data | input | 8 | Write-data byte |
| wr_ready | output | 1 | Write-data byte taken |
| rd_valid | output | 1 | Read-data byte valid |
| rd_data | output | 8 | Read-data byte |

## Verification
Several operation shapes are run, and each separates a different piece of behaviour:
- An opcode-only operation shows whether chip select is released after the first byte.
- A three-byte-address read with one dummy byte exposes errors in address byte order and in dummy filling.
- A quad read of forty bytes after a four-byte address shows whether chunking and the hold flag on each piece are correct.
- A dual write of seventeen bytes, with a second `start` and a changed opcode injected mid-flight, separates correct ignoring of `start` from a re-latched descriptor. It also exercises a one-byte tail chunk.
- An address-only operation and a dummy-only operation with a data length of exactly one buffer show whether the frame ends on the right burst.
- Rejected descriptors test the lane-layout filter and confirm that no burst leaks out.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_ADDR = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    localparam int ADDR_MAX_BYTES = 4;

    function automatic logic lane_code_ok(input logic [2:0] lanes);
        return (lanes == 3'd1) || (lanes == 3'd2) || (lanes == 3'd4);
    endfunction

endpackage

// File: rtl/fcs_desc_check.sv
module fcs_desc_check (
    input  logic [2:0] cmd_lanes,
    input  logic [2:0] addr_bytes,
    input  logic [2:0] addr_lanes,
    input  logic [2:0] data_lanes,
    output logic       desc_ok
);
    import fcs_pkg::*;

    logic cmd_ok;
    logic len_ok;
    logic layout_ok;

    always_comb begin
        cmd_ok    = (cmd_lanes == 3'd1);
        len_ok    = (int'(addr_bytes) <= ADDR_MAX_BYTES);
        // address shares the single lane, or matches the data lanes
        layout_ok = lane_code_ok(data_lanes) &&
                    ((addr_lanes == 3'd1) || (addr_lanes == data_lanes));
        desc_ok   = cmd_ok && len_ok && layout_ok;
    end

endmodule

// File: rtl/fcs_stream_mux.sv
module fcs_stream_mux #(
    parameter int LEN_W = 5
) (
    input  fcs_pkg::phase_e   ph,
    input  logic [7:0]        opcode,
    input  logic [31:0]       addr,
    input  logic [2:0]        addr_bytes,
    input  logic [LEN_W-1:0]  idx,
    input  logic              rx,
    input  logic              m_tx_ready,
    input  logic              m_rx_valid,
    input  logic [7:0]        m_rx_data,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              m_tx_valid,
    output logic [7:0]        m_tx_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    import fcs_pkg::*;

    logic [2:0]  sel;
    logic [31:0] shifted;
    logic        in_addr;

    always_comb begin
        in_addr = (idx < LEN_W'(addr_bytes));
        sel     = addr_bytes - idx[2:0] - 3'd1;
        shifted = addr >> {sel, 3'b000};

        m_tx_valid = 1'b0;
        m_tx_data  = 8'h00;
        wr_ready   = 1'b0;
        rd_valid   = 1'b0;
        rd_data    = m_rx_data;

        unique case (ph)
            PH_CMD: begin
                m_tx_valid = 1'b1;
                m_tx_data  = opcode;
            end
            PH_ADDR: begin
                m_tx_valid = 1'b1;
                m_tx_data  = in_addr ? shifted[7:0] : 8'hFF;
            end
            PH_DATA: begin
                if (rx) begin
                    rd_valid = m_rx_valid;
                end else begin
                    m_tx_valid = wr_valid;
                    m_tx_data  = wr_data;
                    wr_ready   = m_tx_ready;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl #(
    parameter int BUF_BYTES = 16,
    parameter int DUMMY_W   = 4,
    parameter int DLEN_W    = 16,
    parameter int LEN_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               desc_ok,
    input  logic [7:0]         d_opcode,
    input  logic [31:0]        d_addr,
    input  logic [2:0]         d_addr_bytes,
    input  logic [DUMMY_W-1:0] d_dummy_bytes,
    input  logic [DLEN_W-1:0]  d_data_len,
    input  logic               d_data_rx,
    input  logic [2:0]         d_addr_lanes,
    input  logic [2:0]         d_data_lanes,
    input  logic               brq_done,
    input  logic               tx_fire,
    output fcs_pkg::phase_e    ph,
    output logic [7:0]         opcode,
    output logic [31:0]        addr,
    output logic [2:0]         addr_bytes,
    output logic [LEN_W-1:0]   idx,
    output logic               rx,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               brq_start,
    output logic [2:0]         brq_lanes,
    output logic [LEN_W-1:0]   brq_len,
    output logic               brq_hold_cs,
    output logic               brq_rx
);
    import fcs_pkg::*;

    localparam logic [DLEN_W-1:0] BUF_D = DLEN_W'(BUF_BYTES);

    typedef struct packed {
        phase_e             ph;
        logic               req;
        logic               done;
        logic               err;
        logic [7:0]         opcode;
        logic [31:0]        addr;
        logic [2:0]         ab;
        logic [DUMMY_W-1:0] db;
        logic [DLEN_W-1:0]  rem;
        logic               rx;
        logic [2:0]         al;
        logic [2:0]         dl;
        logic [LEN_W-1:0]   idx;
    } state_t;

    state_t st_q, st_d;

    logic [LEN_W-1:0] alen;
    logic             more_chunks;
    logic [LEN_W-1:0] chunk;

    always_comb begin
        alen        = LEN_W'(st_q.ab) + LEN_W'(st_q.db);
        more_chunks = (st_q.rem > BUF_D);
        chunk       = more_chunks ? LEN_W'(BUF_BYTES) : LEN_W'(st_q.rem);

        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.opcode = d_opcode;
                    st_d.addr   = d_addr;
                    st_d.ab     = d_addr_bytes;
                    st_d.db     = d_dummy_bytes;
                    st_d.rem    = d_data_len;
                    st_d.rx     = d_data_rx;
                    st_d.al     = d_addr_lanes;
                    st_d.dl     = d_data_lanes;
                    st_d.idx    = '0;
                    if (desc_ok) begin
                        st_d.ph  = PH_CMD;
                        st_d.req = 1'b1;
                    end else begin
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end
                end
            end
            PH_CMD: begin
                if (brq_done) begin
                    if (alen != '0) begin
                        st_d.ph  = PH_ADDR;
                        st_d.req = 1'b1;
                        st_d.idx = '0;
                    end else if (st_q.rem != '0) begin
                        st_d.ph  = PH_DATA;
                        st_d.req = 1'b1;
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end
                end
            end
            PH_ADDR: begin
                if (tx_fire) begin
                    st_d.idx = st_q.idx + LEN_W'(1);
                end
                if (brq_done) begin
                    if (st_q.rem != '0) begin
                        st_d.ph  = PH_DATA;
                        st_d.req = 1'b1;
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (brq_done) begin
                    if (more_chunks) begin
                        st_d.rem = st_q.rem - BUF_D;
                        st_d.req = 1'b1;
                    end else begin
                        st_d.rem  = '0;
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        brq_lanes   = 3'd0;
        brq_len     = '0;
        brq_hold_cs = 1'b0;
        brq_rx      = 1'b0;
        unique case (st_q.ph)
            PH_CMD: begin
                brq_lanes   = 3'd1;
                brq_len     = LEN_W'(1);
                brq_hold_cs = (alen != '0) || (st_q.rem != '0);
            end
            PH_ADDR: begin
                brq_lanes   = st_q.al;
                brq_len     = alen;
                brq_hold_cs = (st_q.rem != '0);
            end
            PH_DATA: begin
                brq_lanes   = st_q.dl;
                brq_len     = chunk;
                brq_hold_cs = more_chunks;
                brq_rx      = st_q.rx;
            end
            default: ;
        endcase
    end

    assign ph         = st_q.ph;
    assign opcode     = st_q.opcode;
    assign addr       = st_q.addr;
    assign addr_bytes = st_q.ab;
    assign idx        = st_q.idx;
    assign rx         = st_q.rx;
    assign busy       = (st_q.ph != PH_IDLE);
    assign done       = st_q.done;
    assign err        = st_q.err;
    assign brq_start  = st_q.req;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int BUF_BYTES = 16,
    parameter int DUMMY_W   = 4,
    parameter int DLEN_W    = 16,
    localparam int PH_MAX   = (BUF_BYTES > (4 + (1 << DUMMY_W) - 1)) ?
                              BUF_BYTES : (4 + (1 << DUMMY_W) - 1),
    localparam int LEN_W    = $clog2(PH_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         d_opcode,
    input  logic [2:0]         d_cmd_lanes,
    input  logic [31:0]        d_addr,
    input  logic [2:0]         d_addr_bytes,
    input  logic [DUMMY_W-1:0] d_dummy_bytes,
    input  logic [DLEN_W-1:0]  d_data_len,
    input  logic               d_data_rx,
    input  logic [2:0]         d_addr_lanes,
    input  logic [2:0]         d_data_lanes,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               brq_start,
    output logic [2:0]         brq_lanes,
    output logic [LEN_W-1:0]   brq_len,
    output logic               brq_hold_cs,
    output logic               brq_rx,
    input  logic               brq_done,
    output logic               m_tx_valid,
    output logic [7:0]         m_tx_data,
    input  logic               m_tx_ready,
    input  logic               m_rx_valid,
    input  logic [7:0]         m_rx_data,
    input  logic               wr_valid,
    input  logic [7:0]         wr_data,
    output logic               wr_ready,
    output logic               rd_valid,
    output logic [7:0]         rd_data
);
    import fcs_pkg::*;

    logic             desc_ok;
    phase_e           ph;
    logic [7:0]       cur_opcode;
    logic [31:0]      cur_addr;
    logic [2:0]       cur_ab;
    logic [LEN_W-1:0] cur_idx;
    logic             cur_rx;
    logic             tx_fire;

    assign tx_fire = m_tx_valid && m_tx_ready;

    fcs_desc_check u_check (
        .cmd_lanes  (d_cmd_lanes),
        .addr_bytes (d_addr_bytes),
        .addr_lanes (d_addr_lanes),
        .data_lanes (d_data_lanes),
        .desc_ok    (desc_ok)
    );

    fcs_ctrl #(
        .BUF_BYTES (BUF_BYTES),
        .DUMMY_W   (DUMMY_W),
        .DLEN_W    (DLEN_W),
        .LEN_W     (LEN_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .desc_ok       (desc_ok),
        .d_opcode      (d_opcode),
        .d_addr        (d_addr),
        .d_addr_bytes  (d_addr_bytes),
        .d_dummy_bytes (d_dummy_bytes),
        .d_data_len    (d_data_len),
        .d_data_rx     (d_data_rx),
        .d_addr_lanes  (d_addr_lanes),
        .d_data_lanes  (d_data_lanes),
        .brq_done      (brq_done),
        .tx_fire       (tx_fire),
        .ph            (ph),
        .opcode        (cur_opcode),
        .addr          (cur_addr),
        .addr_bytes    (cur_ab),
        .idx           (cur_idx),
        .rx            (cur_rx),
        .busy          (busy),
        .done          (done),
        .err           (err),
        .brq_start     (brq_start),
        .brq_lanes     (brq_lanes),
        .brq_len       (brq_len),
        .brq_hold_cs   (brq_hold_cs),
        .brq_rx        (brq_rx)
    );

    fcs_stream_mux #(
        .LEN_W (LEN_W)
    ) u_mux (
        .ph         (ph),
        .opcode     (cur_opcode),
        .addr       (cur_addr),
        .addr_bytes (cur_ab),
        .idx        (cur_idx),
        .rx         (cur_rx),
        .m_tx_ready (m_tx_ready),
        .m_rx_valid (m_rx_valid),
        .m_rx_data  (m_rx_data),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .m_tx_valid (m_tx_valid),
        .m_tx_data  (m_tx_data),
        .wr_ready   (wr_ready),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             brq_start,
    input logic [2:0]       brq_lanes,
    input logic [LEN_W-1:0] brq_len,
    input logic             brq_hold_cs,
    input logic             brq_done,
    input logic             rd_valid,
    input logic             brq_rx
);
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (brq_start) begin
            outstanding <= 1'b1;
        end else if (brq_done) begin
            outstanding <= 1'b0;
        end
    end

    a_r2_first_burst_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (brq_start && brq_lanes == 3'd1 && brq_len == LEN_W'(1) && !brq_rx));

    a_r3_reject_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !busy && !brq_start));

    a_r8_last_burst_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> !$past(brq_hold_cs));

    a_r9_one_burst_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        brq_start |-> (!outstanding && busy));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r11_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !brq_done) |=> ($stable(brq_len) && $stable(brq_lanes) && $stable(brq_hold_cs)));

    a_r7_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && brq_rx));

endmodule

bind flash_cmd_seq fcs_checker #(.LEN_W(LEN_W)) u_fcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .brq_start   (brq_start),
    .brq_lanes   (brq_lanes),
    .brq_len     (brq_len),
    .brq_hold_cs (brq_hold_cs),
    .brq_done    (brq_done),
    .rd_valid    (rd_valid),
    .brq_rx      (brq_rx)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    localparam int BUF_BYTES = 16;
    localparam int DUMMY_W   = 4;
    localparam int DLEN_W    = 16;
    localparam int LEN_W     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic               start = 1'b0;
    logic [7:0]         d_opcode = '0;
    logic [2:0]         d_cmd_lanes = 3'd1;
    logic [31:0]        d_addr = '0;
    logic [2:0]         d_addr_bytes = '0;
    logic [DUMMY_W-1:0] d_dummy_bytes = '0;
    logic [DLEN_W-1:0]  d_data_len = '0;
    logic               d_data_rx = 1'b0;
    logic [2:0]         d_addr_lanes = 3'd1;
    logic [2:0]         d_data_lanes = 3'd1;
    logic               busy, done, err, brq_start, brq_hold_cs, brq_rx;
    logic [2:0]         brq_lanes;
    logic [LEN_W-1:0]   brq_len;
    logic               brq_done = 1'b0;
    logic               m_tx_valid;
    logic [7:0]         m_tx_data;
    logic               m_tx_ready = 1'b0;
    logic               m_rx_valid = 1'b0;
    logic [7:0]         m_rx_data = '0;
    logic               wr_valid = 1'b0;
    logic [7:0]         wr_data = '0;
    logic               wr_ready, rd_valid;
    logic [7:0]         rd_data;

    flash_cmd_seq #(.BUF_BYTES(BUF_BYTES), .DUMMY_W(DUMMY_W), .DLEN_W(DLEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .d_opcode(d_opcode),
        .d_cmd_lanes(d_cmd_lanes), .d_addr(d_addr), .d_addr_bytes(d_addr_bytes),
        .d_dummy_bytes(d_dummy_bytes), .d_data_len(d_data_len), .d_data_rx(d_data_rx),
        .d_addr_lanes(d_addr_lanes), .d_data_lanes(d_data_lanes),
        .busy(busy), .done(done), .err(err), .brq_start(brq_start),
        .brq_lanes(brq_lanes), .brq_len(brq_len), .brq_hold_cs(brq_hold_cs),
        .brq_rx(brq_rx), .brq_done(brq_done), .m_tx_valid(m_tx_valid),
        .m_tx_data(m_tx_data), .m_tx_ready(m_tx_ready), .m_rx_valid(m_rx_valid),
        .m_rx_data(m_rx_data), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit expect_busy = 1'b0;

    // reference model: queued bursts and bytes
    int q_lanes[$];
    int q_len[$];
    int q_hold[$];
    int q_rx[$];
    int q_kind[$];   // 0 generated byte, 1 write stream byte
    int q_bytes[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison of the busy flag with the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(busy == expect_busy, "R10", "busy vs model", int'(busy), int'(expect_busy));
        end
    end

    task automatic build_model(input logic [7:0] op, input logic [31:0] a, input int ab,
                               input int db, input int dlen, input bit rx,
                               input int al, input int dl);
        int rem;
        q_lanes.delete(); q_len.delete(); q_hold.delete(); q_rx.delete();
        q_kind.delete(); q_bytes.delete();
        q_lanes.push_back(1); q_len.push_back(1);
        q_hold.push_back((ab + db + dlen) > 0 ? 1 : 0); q_rx.push_back(0);
        q_kind.push_back(0); q_bytes.push_back(int'(op));
        if (ab + db > 0) begin
            q_lanes.push_back(al); q_len.push_back(ab + db);
            q_hold.push_back(dlen > 0 ? 1 : 0); q_rx.push_back(0);
            for (int k = ab - 1; k >= 0; k--) begin
                q_kind.push_back(0); q_bytes.push_back(int'((a >> (8 * k)) & 32'hFF));
            end
            for (int k = 0; k < db; k++) begin
                q_kind.push_back(0); q_bytes.push_back(8'hFF);
            end
        end
        rem = dlen;
        for (int n = 0; rem > 0; n++) begin
            int c;
            c = (rem > BUF_BYTES) ? BUF_BYTES : rem;
            q_lanes.push_back(dl); q_len.push_back(c);
            q_hold.push_back(rem > c ? 1 : 0); q_rx.push_back(rx ? 1 : 0);
            for (int k = 0; k < c; k++) begin
                q_kind.push_back(1);
                q_bytes.push_back((dlen * 3 + n * 16 + k * 7 + 5) & 8'hFF);
            end
            rem -= c;
        end
    endtask

    task automatic run_op(input string tag, input logic [7:0] op, input logic [31:0] a,
                          input int ab, input int db, input int dlen, input bit rx,
                          input int al, input int dl, input bit poke);
        int nb;
        build_model(op, a, ab, db, dlen, rx, al, dl);
        @(negedge clk);
        d_opcode = op; d_cmd_lanes = 3'd1; d_addr = a; d_addr_bytes = 3'(ab);
        d_dummy_bytes = DUMMY_W'(db); d_data_len = DLEN_W'(dlen); d_data_rx = rx;
        d_addr_lanes = 3'(al); d_data_lanes = 3'(dl);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        expect_busy = 1'b1;
        nb = q_len.size();
        for (int b = 0; b < nb; b++) begin
            int ln, hd, rxb, lanes;
            ln = q_len.pop_front(); hd = q_hold.pop_front();
            rxb = q_rx.pop_front(); lanes = q_lanes.pop_front();
            if (poke && b == 0) begin
                start = 1'b1; d_opcode = ~op; d_data_len = DLEN_W'(3);
            end
            #1;
            check(brq_start == 1'b1, "R9", {tag, " burst request"}, int'(brq_start), 1);
            check(int'(brq_lanes) == lanes, "R7", {tag, " lanes"}, int'(brq_lanes), lanes);
            check(int'(brq_len) == ln, "R8", {tag, " length"}, int'(brq_len), ln);
            check(int'(brq_hold_cs) == hd, "R6", {tag, " hold cs"}, int'(brq_hold_cs), hd);
            check(int'(brq_rx) == rxb, "R7", {tag, " direction"}, int'(brq_rx), rxb);
            for (int k = 0; k < ln; k++) begin
                int kind, val;
                kind = q_kind.pop_front(); val = q_bytes.pop_front();
                if (rxb != 0) begin
                    m_rx_valid = 1'b1; m_rx_data = 8'(val);
                    #1;
                    check(rd_valid && int'(rd_data) == val, "R7", {tag, " read byte"},
                          int'(rd_data), val);
                    check(!m_tx_valid && !wr_ready, "R7", {tag, " tx idle in read"},
                          int'(m_tx_valid), 0);
                end else begin
                    m_tx_ready = 1'b1;
                    if (kind == 1) begin
                        wr_valid = 1'b1; wr_data = 8'(val);
                    end
                    #1;
                    check(m_tx_valid && int'(m_tx_data) == val, "R5", {tag, " tx byte"},
                          int'(m_tx_data), val);
                    check(wr_ready == (kind == 1), "R7", {tag, " write stream gate"},
                          int'(wr_ready), kind);
                    check(!rd_valid, "R7", {tag, " read idle"}, int'(rd_valid), 0);
                end
                @(posedge clk);
                @(negedge clk);
                m_tx_ready = 1'b0; m_rx_valid = 1'b0; wr_valid = 1'b0; start = 1'b0;
                check(!brq_start, "R9", {tag, " no request mid-burst"}, int'(brq_start), 0);
            end
            brq_done = 1'b1;
            @(posedge clk);
            @(negedge clk);
            brq_done = 1'b0;
            if (b == nb - 1) begin
                expect_busy = 1'b0;
                #1;
                check(done && !err && !busy, "R10", {tag, " done pulse"},
                      int'({done, err, busy}), 3'b100);
            end
        end
        @(negedge clk);
        #1;
        check(!done && !brq_start, "R10", {tag, " done single cycle"}, int'(done), 0);
    endtask

    task automatic run_bad(input string tag, input int cl, input int ab,
                           input int al, input int dl);
        @(negedge clk);
        d_opcode = 8'h5A; d_cmd_lanes = 3'(cl); d_addr_bytes = 3'(ab);
        d_dummy_bytes = '0; d_data_len = DLEN_W'(4); d_addr_lanes = 3'(al);
        d_data_lanes = 3'(dl); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        #1;
        check(done && err && !busy && !brq_start, "R3", {tag, " rejected"},
              int'({done, err, busy, brq_start}), 4'b1100);
        @(negedge clk);
        #1;
        check(!done && !err && !busy && !brq_start, "R2", {tag, " no burst after reject"},
              int'({done, err, busy, brq_start}), 0);
        d_cmd_lanes = 3'd1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !err && !brq_start, "R1", "reset outputs",
              int'({busy, done, err, brq_start}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy && !done && !err && !brq_start, "R1", "after reset release",
              int'({busy, done, err, brq_start}), 0);

        run_op("R4 opcode only",      8'h06, 32'h0,        0, 0, 0,  1'b0, 1, 1, 1'b0);
        run_op("R5 read 1-1-1",       8'h0B, 32'h00A1B2C3, 3, 1, 5,  1'b1, 1, 1, 1'b0);
        run_op("R8 quad read 1-4-4",  8'hEC, 32'h12345678, 4, 2, 40, 1'b1, 4, 4, 1'b0);
        run_op("R11 dual write 1-1-2",8'hA2, 32'h00000102, 2, 0, 17, 1'b0, 1, 2, 1'b1);
        run_op("R6 address only 1-2-2",8'h20, 32'h00ABCDEF, 3, 0, 0, 1'b0, 2, 2, 1'b0);
        run_op("R8 dummy only 1-1-4", 8'h6B, 32'h0,        0, 1, 16, 1'b1, 1, 4, 1'b0);

        run_bad("R2 two-lane command", 2, 3, 1, 1);
        run_bad("R3 layout 1-2-1",     1, 3, 2, 1);
        run_bad("R3 layout 1-2-4",     1, 3, 2, 4);
        run_bad("R3 five address bytes", 1, 5, 1, 1);
        run_bad("R3 data lanes 3",     1, 3, 1, 3);

        run_op("R2 after reject",     8'h9F, 32'h0,        0, 0, 3,  1'b1, 1, 1, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule